// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block picks the operating mode of a small system-on-chip and drives the enables that carry that choice out to the clock and power fabric. There are four modes, each saving more power than the last. In normal mode every clock runs and each peripheral clock has its own software-owned gate bit. Idle mode stops only the CPU clock. Stop mode turns off both PLLs and freezes every clock. Sleep mode also asks for the switched core supply to be cut, and only the separately powered wake-up domain (this block) keeps running.

Software picks a mode by writing a 2-bit code while the system is in normal mode. An enabled interrupt ends idle. Only the wake input ends stop or sleep. Leaving stop holds the clocks gated for a programmable relock time with the PLLs already running. Leaving sleep restores power first, then holds the core in reset for a fixed count, and sets a sleep-exit flag on the same edge that normal mode resumes. Every clock gate enable is retimed to the falling clock edge, so a gated clock never carries a runt pulse.

Top module: `pmc_power_seq`

## Requirements
- R1: During and after reset the mode is normal (`mode_o` = 00) and `busy_o` is low. The CPU, AHB, APB and all peripheral clock enables are high, both PLL enables are high, core power is on, `core_rst_no` is high, and slow bypass and the sleep-exit flag are low.
- R2: In normal mode, a write on `mode_we_i` with code 00 normal, 01 idle, 10 stop or 11 sleep takes effect at the next rising edge. `mode_o` reports that code and `busy_o` is high in every mode other than normal. Mode writes made outside normal mode are ignored.
- R3: In normal mode, `periph_clk_en_o[i]` follows bit i of the gate mask, which is loaded by `cfg_we_i`. Configuration writes made outside normal mode are ignored.
- R4: In idle mode only the CPU clock enable is low. The AHB and APB enables stay high, the peripheral enables keep the mask value, and both PLLs stay on.
- R5: Idle mode returns to normal at the next edge once any bit of `irq_i & irq_en_i` is set. Unenabled interrupts and `wake_i` have no effect in idle.
- R6: In stop mode every clock enable and both PLL enables are low, and interrupts are ignored.
- R7: When `wake_i` arrives in stop mode, both PLLs turn on while all clock enables stay low for `lock_cycles_i` cycles (a value of 0 counts as 1). After that the block is back in normal mode.
- R8: In sleep mode `core_pwr_off_o` is high, `core_rst_no` is low, and every PLL and clock enable is low. Interrupts are ignored.
- R9: When `wake_i` arrives in sleep mode, core power returns at once. The core reset and the clock gating are held for exactly 16 cycles. On the edge that ends them the block enters normal mode with `sleep_exit_o` set. The flag is cleared by the next accepted mode write.
- R10: Each clock enable changes only at a falling clock edge. A mode change seen at a rising edge reaches the enables half a cycle later.
- R11: `slow_bypass_o` follows the slow-select bit of the configuration write, and it keeps that value in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Mode request write strobe |
| mode_code_i | input | 2 | Requested mode code |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_gate_mask_i | input | NUM_PERIPH | Per-peripheral clock gate mask |
| cfg_slow_i | input | 1 | Slow-clock (PLL bypass) select |
| lock_cycles_i | input | LOCK_W | PLL relock time in cycles |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| irq_en_i | input | NUM_IRQ | Interrupt enables |
| wake_i | input | 1 | External wake-up event |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| ahb_clk_en_o | output | 1 | AHB-side clock gate enable |
| apb_clk_en_o | output | 1 | APB-side clock gate enable |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock gate enables |
| pll_main_en_o | output | 1 | System PLL enable |
| pll_aux_en_o | output | 1 | USB / IrDA / camera PLL enable |
| slow_bypass_o | output | 1 | Selects the reference clock instead of the PLL |
| core_pwr_off_o | output | 1 | Request to switch off the core supply |
| core_rst_no | output | 1 | Active-low reset to the core domain |
| busy_o | output | 1 | High in any mode other than normal |
| mode_o | output | 2 | Current mode code |
| sleep_exit_o | output | 1 | Set on return to normal after sleep |

## Verification
The mode code, busy flag, PLL enables, power request and core reset come from the state register, so they change at the first rising edge after a write or wake. The clock enables change one falling edge later. The bench drives inputs and samples outputs 8 ns into each 10 ns period, which is after that falling edge, so both kinds of output already show the new state there. One extra sample taken 2 ns after the rising edge catches a clock enable that changes too early. The relock and power-up windows are checked sample by sample: the bench expects max(L,1) gated samples after a stop wake and 16 after a sleep wake, then normal mode on the next sample.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_STOP  = 3'd2,
      ST_LOCK  = 3'd3,
      ST_SLEEP = 3'd4,
      ST_PWRUP = 3'd5
   } pmc_state_e;

   localparam logic [1:0] MODE_NORMAL = 2'b00;
   localparam logic [1:0] MODE_IDLE   = 2'b01;
   localparam logic [1:0] MODE_STOP   = 2'b10;
   localparam logic [1:0] MODE_SLEEP  = 2'b11;

   function automatic logic [1:0] mode_of(input pmc_state_e st);
      case (st)
         ST_IDLE:           return MODE_IDLE;
         ST_STOP, ST_LOCK:  return MODE_STOP;
         ST_SLEEP, ST_PWRUP: return MODE_SLEEP;
         default:           return MODE_NORMAL;
      endcase
   endfunction

endpackage

// File: rtl/pmc_gate_en.sv
module pmc_gate_en #(
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic en_o
);

   // Retime on the falling edge: the enable moves only while the clock is low.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_o <= RST_VAL;
      else         en_o <= en_i;
   end

   always @(en_o) begin
      if (rst_ni) begin
         a_r10_low_change: assert (clk_i == 1'b0)
            else $error("R10: gate enable moved while clock high");
      end
   end

endmodule

// File: rtl/pmc_seq_fsm.sv
module pmc_seq_fsm
   import pmc_pkg::*;
#(
   parameter int NUM_IRQ    = 8,
   parameter int LOCK_W     = 8,
   parameter int RST_CYCLES = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_we_i,
   input  logic [1:0]        mode_code_i,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic [NUM_IRQ-1:0] irq_en_i,
   input  logic              wake_i,
   input  logic [LOCK_W-1:0] lock_cycles_i,
   output pmc_state_e        state_o,
   output logic              sleep_exit_o
);

   localparam int RST_W = $clog2(RST_CYCLES);
   localparam int CNT_W = (LOCK_W > RST_W) ? LOCK_W : RST_W;
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);

   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end
   if (RST_CYCLES < 2) begin : g_bad_rst
      $error("RST_CYCLES must be at least 2");
   end

   pmc_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             exit_q;
   logic             irq_hit;
   logic [CNT_W-1:0] lock_last;

   assign irq_hit   = |(irq_i & irq_en_i);
   assign lock_last = (lock_cycles_i == '0) ? '0 : (CNT_W'(lock_cycles_i) - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_RUN;
         cnt_q  <= '0;
         exit_q <= 1'b0;
      end else begin
         case (st_q)
            ST_RUN: begin
               if (mode_we_i) begin
                  exit_q <= 1'b0;
                  case (mode_code_i)
                     MODE_IDLE:  st_q <= ST_IDLE;
                     MODE_STOP:  st_q <= ST_STOP;
                     MODE_SLEEP: st_q <= ST_SLEEP;
                     default:    st_q <= ST_RUN;
                  endcase
               end
            end
            ST_IDLE: if (irq_hit) st_q <= ST_RUN;
            ST_STOP: begin
               if (wake_i) begin
                  st_q  <= ST_LOCK;
                  cnt_q <= lock_last;
               end
            end
            ST_LOCK: begin
               if (cnt_q == '0) st_q <= ST_RUN;
               else             cnt_q <= cnt_q - 1'b1;
            end
            ST_SLEEP: begin
               if (wake_i) begin
                  st_q  <= ST_PWRUP;
                  cnt_q <= RST_LAST;
               end
            end
            ST_PWRUP: begin
               if (cnt_q == '0) begin
                  st_q   <= ST_RUN;
                  exit_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign state_o      = st_q;
   assign sleep_exit_o = exit_q;

   a_r2_write_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && mode_we_i) |=> (mode_of(st_q) == $past(mode_code_i)));

   a_r5_idle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && irq_hit) |=> (st_q == ST_RUN));

   a_r6_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_STOP && !wake_i) |=> (st_q == ST_STOP));

   a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_LOCK && cnt_q != '0) |=> (st_q == ST_LOCK));

   a_r8_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SLEEP && !wake_i) |=> (st_q == ST_SLEEP));

endmodule

// File: rtl/pmc_power_seq.sv
module pmc_power_seq
   import pmc_pkg::*;
#(
   parameter int NUM_PERIPH = 8,
   parameter int NUM_IRQ    = 8,
   parameter int LOCK_W     = 8,
   parameter int RST_CYCLES = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  mode_we_i,
   input  logic [1:0]            mode_code_i,
   input  logic                  cfg_we_i,
   input  logic [NUM_PERIPH-1:0] cfg_gate_mask_i,
   input  logic                  cfg_slow_i,
   input  logic [LOCK_W-1:0]     lock_cycles_i,
   input  logic [NUM_IRQ-1:0]    irq_i,
   input  logic [NUM_IRQ-1:0]    irq_en_i,
   input  logic                  wake_i,
   output logic                  cpu_clk_en_o,
   output logic                  ahb_clk_en_o,
   output logic                  apb_clk_en_o,
   output logic [NUM_PERIPH-1:0] periph_clk_en_o,
   output logic                  pll_main_en_o,
   output logic                  pll_aux_en_o,
   output logic                  slow_bypass_o,
   output logic                  core_pwr_off_o,
   output logic                  core_rst_no,
   output logic                  busy_o,
   output logic [1:0]            mode_o,
   output logic                  sleep_exit_o
);

   localparam int NUM_SYS   = 3;
   localparam int NUM_GATES = NUM_SYS + NUM_PERIPH;

   if (NUM_PERIPH < 1 || NUM_PERIPH > 32) begin : g_bad_periph
      $error("NUM_PERIPH must be within 1..32");
   end
   if (LOCK_W < 1) begin : g_bad_lock
      $error("LOCK_W must be at least 1");
   end

   pmc_state_e            st;
   logic [NUM_PERIPH-1:0] mask_q;
   logic                  slow_q;
   logic                  run_on, bus_on, pll_on;
   logic [NUM_GATES-1:0]  gate_d, gate_q;

   pmc_seq_fsm #(
      .NUM_IRQ    (NUM_IRQ),
      .LOCK_W     (LOCK_W),
      .RST_CYCLES (RST_CYCLES)
   ) fsm_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .mode_we_i     (mode_we_i),
      .mode_code_i   (mode_code_i),
      .irq_i         (irq_i),
      .irq_en_i      (irq_en_i),
      .wake_i        (wake_i),
      .lock_cycles_i (lock_cycles_i),
      .state_o       (st),
      .sleep_exit_o  (sleep_exit_o)
   );

   // Configuration: accepted only while the CPU runs in normal mode.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '1;
         slow_q <= 1'b0;
      end else if (cfg_we_i && st == ST_RUN) begin
         mask_q <= cfg_gate_mask_i;
         slow_q <= cfg_slow_i;
      end
   end

   assign run_on = (st == ST_RUN);
   assign bus_on = (st == ST_RUN) || (st == ST_IDLE);
   assign pll_on = !((st == ST_STOP) || (st == ST_SLEEP));

   assign gate_d[0] = run_on;
   assign gate_d[1] = bus_on;
   assign gate_d[2] = bus_on;
   assign gate_d[NUM_GATES-1:NUM_SYS] = mask_q & {NUM_PERIPH{bus_on}};

   for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      pmc_gate_en #(.RST_VAL(1'b1)) gate_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (gate_d[g]),
         .en_o   (gate_q[g])
      );
   end

   assign cpu_clk_en_o    = gate_q[0];
   assign ahb_clk_en_o    = gate_q[1];
   assign apb_clk_en_o    = gate_q[2];
   assign periph_clk_en_o = gate_q[NUM_GATES-1:NUM_SYS];

   assign pll_main_en_o  = pll_on;
   assign pll_aux_en_o   = pll_on;
   assign slow_bypass_o  = slow_q;
   assign core_pwr_off_o = (st == ST_SLEEP);
   assign core_rst_no    = !((st == ST_SLEEP) || (st == ST_PWRUP));
   assign busy_o         = (st != ST_RUN);
   assign mode_o         = mode_of(st);

   a_r7_lock_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_LOCK) |-> (gate_q == '0));

   a_r9_pwrup_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_PWRUP) |-> (gate_q == '0));

   a_r9_exit_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_rst_no) |-> sleep_exit_o);

   a_r8_power_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_pwr_off_o |-> (!cpu_clk_en_o || $past(st) == ST_RUN));

endmodule

// File: tb/pmc_power_seq_tb_top.sv
module pmc_power_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int NI = 2;
   localparam int LW = 4;
   localparam int RSTC = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_we = 1'b0;
   logic [1:0]    mode_code = 2'b00;
   logic          cfg_we = 1'b0;
   logic [NP-1:0] cfg_mask = '1;
   logic          cfg_slow = 1'b0;
   logic [LW-1:0] lock_cyc = '0;
   logic [NI-1:0] irq = '0;
   logic [NI-1:0] irq_en = '0;
   logic          wake = 1'b0;

   logic          cpu_en, ahb_en, apb_en, pll_m, pll_a, slow_o, pwr_off, crst_n, busy, sexit;
   logic [NP-1:0] per_en;
   logic [1:0]    mode;

   int n_chk = 0;
   int n_err = 0;
   logic [NP-1:0] cur_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmc_power_seq #(
      .NUM_PERIPH(NP), .NUM_IRQ(NI), .LOCK_W(LW), .RST_CYCLES(RSTC)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .mode_we_i(mode_we), .mode_code_i(mode_code),
      .cfg_we_i(cfg_we), .cfg_gate_mask_i(cfg_mask), .cfg_slow_i(cfg_slow),
      .lock_cycles_i(lock_cyc), .irq_i(irq), .irq_en_i(irq_en), .wake_i(wake),
      .cpu_clk_en_o(cpu_en), .ahb_clk_en_o(ahb_en), .apb_clk_en_o(apb_en),
      .periph_clk_en_o(per_en), .pll_main_en_o(pll_m), .pll_aux_en_o(pll_a),
      .slow_bypass_o(slow_o), .core_pwr_off_o(pwr_off), .core_rst_no(crst_n),
      .busy_o(busy), .mode_o(mode), .sleep_exit_o(sexit)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Advance to 8 ns after the next rising edge (past the falling edge).
   task automatic cyc();
      @(posedge clk);
      #8;
   endtask

   task automatic write_mode(input logic [1:0] m);
      mode_code = m;
      mode_we = 1'b1;
      cyc();
      mode_we = 1'b0;
   endtask

   task automatic write_cfg(input logic [NP-1:0] m, input logic s);
      cfg_mask = m;
      cfg_slow = s;
      cfg_we = 1'b1;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic chk_clocks(input string req, input logic c, input logic b,
                             input logic [NP-1:0] p);
      chk(req, "cpu_en", 32'(cpu_en), 32'(c));
      chk(req, "ahb_en", 32'(ahb_en), 32'(b));
      chk(req, "apb_en", 32'(apb_en), 32'(b));
      chk(req, "periph_en", 32'(per_en), 32'(p));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #8;
      // R1: values held during reset
      chk("R1", "mode in reset", 32'(mode), 32'(0));
      chk_clocks("R1", 1'b1, 1'b1, '1);
      rst_n = 1'b1;
      cyc();
      // R1: after release
      chk("R1", "mode", 32'(mode), 32'(0));
      chk("R1", "busy", 32'(busy), 32'(0));
      chk_clocks("R1", 1'b1, 1'b1, '1);
      chk("R1", "plls", 32'({pll_m, pll_a}), 32'(3));
      chk("R1", "pwr_off", 32'(pwr_off), 32'(0));
      chk("R1", "core_rst_n", 32'(crst_n), 32'(1));
      chk("R1", "slow", 32'(slow_o), 32'(0));
      chk("R1", "sleep_exit", 32'(sexit), 32'(0));

      // R3 / R11: sweep every gate mask in normal mode
      for (int m = 0; m < (1 << NP); m++) begin
         write_cfg(NP'(m), m[0]);
         chk("R3", "periph_en normal", 32'(per_en), 32'(m));
         chk("R11", "slow follows cfg", 32'(slow_o), 32'(m[0]));
         chk("R3", "cpu stays on", 32'(cpu_en), 32'(1));
      end

      // R4 / R2 / R3: idle with every mask, writes ignored while idle
      irq_en = '1;
      for (int m = 0; m < (1 << NP); m++) begin
         write_cfg(NP'(m), 1'b0);
         write_mode(2'b01);
         chk("R2", "idle code", 32'(mode), 32'(1));
         chk("R2", "busy idle", 32'(busy), 32'(1));
         chk_clocks("R4", 1'b0, 1'b1, NP'(m));
         chk("R4", "plls idle", 32'({pll_m, pll_a}), 32'(3));
         write_mode(2'b11);
         chk("R2", "write ignored in idle", 32'(mode), 32'(1));
         write_cfg(~NP'(m), 1'b1);
         chk("R3", "cfg ignored in idle", 32'(per_en), 32'(m));
         chk("R11", "slow cfg ignored", 32'(slow_o), 32'(0));
         irq = 2'b01;
         cyc();
         irq = '0;
         chk("R5", "idle exit", 32'(mode), 32'(0));
      end

      // R5: exhaustive irq/enable pairs against idle
      for (int v = 0; v < 16; v++) begin
         logic [NI-1:0] iv, ev;
         iv = NI'(v);
         ev = NI'(v >> 2);
         if (mode != 2'b01) write_mode(2'b01);
         irq = iv;
         irq_en = ev;
         wake = 1'b1;
         cyc();
         irq = '0;
         wake = 1'b0;
         chk("R5", "irq/enable combo", 32'(mode), ((iv & ev) != 0) ? 32'(0) : 32'(1));
      end
      if (mode != 2'b00) begin
         irq_en = '1; irq = '1; cyc(); irq = '0;
      end
      write_cfg('1, 1'b0);
      cur_mask = '1;

      // R10: enable moves half a cycle after the state edge
      mode_code = 2'b01;
      mode_we = 1'b1;
      @(posedge clk);
      #2;
      mode_we = 1'b0;
      chk("R10", "mode already idle", 32'(mode), 32'(1));
      chk("R10", "cpu_en before falling edge", 32'(cpu_en), 32'(1));
      #6;
      chk("R10", "cpu_en after falling edge", 32'(cpu_en), 32'(0));
      irq_en = '1; irq = '1; cyc(); irq = '0;
      #0;
      chk("R10", "cpu_en back", 32'(cpu_en), 32'(1));

      // R6 / R7: stop with a sweep of relock times
      for (int l = 0; l < 6; l++) begin
         int exp_gated;
         exp_gated = (l == 0) ? 1 : l;
         lock_cyc = LW'(l);
         write_cfg(cur_mask, 1'b1);
         write_mode(2'b10);
         chk("R6", "stop code", 32'(mode), 32'(2));
         chk_clocks("R6", 1'b0, 1'b0, '0);
         chk("R6", "plls off", 32'({pll_m, pll_a}), 32'(0));
         chk("R11", "slow kept in stop", 32'(slow_o), 32'(1));
         irq = '1;
         cyc();
         irq = '0;
         chk("R6", "irq ignored in stop", 32'(mode), 32'(2));
         wake = 1'b1;
         cyc();
         wake = 1'b0;
         for (int k = 0; k < exp_gated; k++) begin
            chk("R7", "gated during relock", 32'(cpu_en), 32'(0));
            chk("R7", "plls on during relock", 32'({pll_m, pll_a}), 32'(3));
            chk("R7", "still busy", 32'(busy), 32'(1));
            cyc();
         end
         chk("R7", "normal after relock", 32'(mode), 32'(0));
         chk_clocks("R7", 1'b1, 1'b1, cur_mask);
      end

      // R8 / R9: sleep and power-up sequence
      write_mode(2'b11);
      chk("R8", "sleep code", 32'(mode), 32'(3));
      chk("R8", "pwr_off", 32'(pwr_off), 32'(1));
      chk("R8", "core_rst_n", 32'(crst_n), 32'(0));
      chk("R8", "plls off", 32'({pll_m, pll_a}), 32'(0));
      chk_clocks("R8", 1'b0, 1'b0, '0);
      irq = '1;
      cyc();
      irq = '0;
      chk("R8", "irq ignored in sleep", 32'(mode), 32'(3));
      wake = 1'b1;
      cyc();
      wake = 1'b0;
      for (int k = 0; k < RSTC; k++) begin
         chk("R9", "power restored", 32'(pwr_off), 32'(0));
         chk("R9", "reset held", 32'(crst_n), 32'(0));
         chk("R9", "clocks gated", 32'(cpu_en), 32'(0));
         cyc();
      end
      chk("R9", "normal after power-up", 32'(mode), 32'(0));
      chk("R9", "reset released", 32'(crst_n), 32'(1));
      chk("R9", "sleep_exit set", 32'(sexit), 32'(1));
      write_mode(2'b00);
      chk("R9", "sleep_exit cleared", 32'(sexit), 32'(0));
      chk("R2", "normal code", 32'(mode), 32'(0));
      chk("R2", "busy low", 32'(busy), 32'(0));

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule